// File: doc/BRIEF.md
# Timed Sleep Duration Controller

This block sequences the timed sleep of a radio link controller. Slow-clock time is measured by two duration counters. The block accepts a sleep request only while hardware clock control is enabled. It then raises a power-down request toward the power manager and blocks CPU access to the link controller. On the next slow-clock rising edge it drops the enables of the local 1 MHz and 12 MHz clocks and halts the sequencer.

The first counter covers a power-down window of M+1 slow-clock ticks, and at its end the power-down request is released. The second counter then covers a clock-restart window of N+1 ticks. After that, the local clocks and the sequencer run again, a one-cycle wake-up pulse goes to the wake-up interrupt unit, and an interrupt goes out with it if interrupts are enabled. The CPU lockout ends in the cycle after the wake-up pulse.

The block runs on the system clock. Slow-clock rising edges reach it as a one-cycle strobe, `slow_tick_i`. M and N come from input ports and are latched when the request is accepted.

Top module: `sleep_dur_ctrl`

## Requirements
- R1: After synchronous reset the block is idle. `clk1m_en_o`, `clk12m_en_o` and `seq_run_o` are high, and `pd_req_o`, `cpu_lock_o`, `wake_o` and `irq_o` are low.
- R2: A sleep request seen while `hcc_en_i` is low is ignored. `pd_req_o` and `cpu_lock_o` stay low and the clock enables stay high, whatever slow ticks arrive.
- R3: When `sleep_req_i` and `hcc_en_i` are both high in an idle cycle, `pd_req_o` and `cpu_lock_o` are high from the next cycle on. The clock enables stay high until a slow tick arrives after that point. A tick in the accepting cycle itself does not count.
- R4: The first slow tick seen while `pd_req_o` is high and the clocks still run drives `clk1m_en_o`, `clk12m_en_o` and `seq_run_o` low from the next cycle on.
- R5: After the clocks stop, `pd_req_o` goes low in the cycle after the (M+1)-th slow tick. M = 0 means one tick.
- R6: After `pd_req_o` falls, the two clock enables and `seq_run_o` go high in the cycle after the (N+1)-th slow tick. N = 0 means one tick.
- R7: `wake_o` is high for exactly one cycle, the first cycle in which the clocks are back on.
- R8: `irq_o` is high in the wake-up cycle only if `irq_en_i` is high in that cycle. Otherwise it stays low.
- R9: `cpu_lock_o` stays high from the cycle after acceptance through the wake-up cycle, and is low in the cycle after that.
- R10: M and N are taken from `m_count_i` and `n_count_i` in the accepting cycle. Later changes on those ports do not alter the running sleep.
- R11: A sleep request arriving while a sleep is in progress, including in the wake-up cycle, is ignored. No second sleep follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| slow_tick_i | input | 1 | One-cycle strobe per slow-clock rising edge |
| sleep_req_i | input | 1 | Request to enter timed sleep |
| hcc_en_i | input | 1 | Hardware clock control enable |
| irq_en_i | input | 1 | Interrupt enable for the wake-up event |
| m_count_i | input | CNT_W | Power-down window length minus one, in slow ticks |
| n_count_i | input | CNT_W | Clock-restart window length minus one, in slow ticks |
| pd_req_o | output | 1 | Power-down request to the power manager |
| clk1m_en_o | output | 1 | Local 1 MHz clock enable |
| clk12m_en_o | output | 1 | Local 12 MHz clock enable |
| seq_run_o | output | 1 | Sequencer run enable |
| cpu_lock_o | output | 1 | CPU access lockout |
| wake_o | output | 1 | One-cycle wake-up pulse |
| irq_o | output | 1 | Wake-up interrupt |

## Verification
Two events can land on the same system-clock cycle, and the bench targets both. The first is a slow tick in the very cycle a sleep request is accepted. The bench drives the tick together with the request and checks that the clocks are still on one cycle later, so that only a later tick stops them. The second is a new sleep request during the wake-up cycle. The bench holds the request high through a whole sleep, including the wake-up cycle. It then checks that the lockout and the power-down request are low in the cycle after wake-up and stay low.

// File: rtl/slp_pkg.sv
package slp_pkg;

   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_ARM     = 3'd1,
      S_PDWN    = 3'd2,
      S_RESTART = 3'd3,
      S_WAKE    = 3'd4
   } slp_state_e;

endpackage

// File: rtl/slp_dur_counter.sv
module slp_dur_counter #(
   parameter int CNT_W      = 16,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             run_i,
   input  logic             tick_i,
   output logic             done_o
);

   initial assert (CNT_W >= 1 && CNT_W <= 32);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic step;
   assign step = run_i & tick_i;

   generate
      if (COUNT_DOWN) begin : g_down
         logic [CNT_W-1:0] rem_q;

         always_ff @(posedge clk_i) begin
            if (rst_i)
               rem_q <= ZERO;
            else if (load_i)
               rem_q <= limit_i;
            else if (step && rem_q != ZERO)
               rem_q <= rem_q - ONE;
         end

         assign done_o = step && (rem_q == ZERO);
      end else begin : g_up
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] lim_q;

         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               cnt_q <= ZERO;
               lim_q <= ZERO;
            end else if (load_i) begin
               cnt_q <= ZERO;
               lim_q <= limit_i;
            end else if (step) begin
               cnt_q <= cnt_q + ONE;
            end
         end

         assign done_o = step && (cnt_q == lim_q);

         // R5/R6: the running count never passes its latched limit
         p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            run_i |-> (cnt_q <= lim_q));
      end
   endgenerate

endmodule

// File: rtl/slp_seq_fsm.sv
module slp_seq_fsm
   import slp_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       tick_i,
   input  logic       sleep_req_i,
   input  logic       hcc_en_i,
   input  logic       m_done_i,
   input  logic       n_done_i,
   output slp_state_e state_o,
   output logic       accept_o
);

   slp_state_e state_q, state_d;

   assign accept_o = (state_q == S_IDLE) && sleep_req_i && hcc_en_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:    if (accept_o) state_d = S_ARM;
         S_ARM:     if (tick_i)   state_d = S_PDWN;
         S_PDWN:    if (m_done_i) state_d = S_RESTART;
         S_RESTART: if (n_done_i) state_d = S_WAKE;
         S_WAKE:                  state_d = S_IDLE;
         default:                 state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= S_IDLE;
      else       state_q <= state_d;
   end

   assign state_o = state_q;

   // R11: leaving idle happens only from idle, on an enabled request
   p_enter_from_idle_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == S_ARM && $past(state_q) != S_ARM) |->
         ($past(state_q) == S_IDLE && $past(hcc_en_i) && $past(sleep_req_i)));

   // R7: the wake state lasts a single cycle
   p_wake_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == S_WAKE) |=> (state_q == S_IDLE));

endmodule

// File: rtl/sleep_dur_ctrl.sv
module sleep_dur_ctrl
   import slp_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             slow_tick_i,
   input  logic             sleep_req_i,
   input  logic             hcc_en_i,
   input  logic             irq_en_i,
   input  logic [CNT_W-1:0] m_count_i,
   input  logic [CNT_W-1:0] n_count_i,
   output logic             pd_req_o,
   output logic             clk1m_en_o,
   output logic             clk12m_en_o,
   output logic             seq_run_o,
   output logic             cpu_lock_o,
   output logic             wake_o,
   output logic             irq_o
);

   initial assert (CNT_W >= 1 && CNT_W <= 32);

   slp_state_e state;
   logic       accept;
   logic       m_done;
   logic       n_done;
   logic       clocks_off;

   slp_seq_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .tick_i      (slow_tick_i),
      .sleep_req_i (sleep_req_i),
      .hcc_en_i    (hcc_en_i),
      .m_done_i    (m_done),
      .n_done_i    (n_done),
      .state_o     (state),
      .accept_o    (accept)
   );

   slp_dur_counter #(.CNT_W(CNT_W), .COUNT_DOWN(COUNT_DOWN)) u_m_cnt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (accept),
      .limit_i (m_count_i),
      .run_i   (state == S_PDWN),
      .tick_i  (slow_tick_i),
      .done_o  (m_done)
   );

   slp_dur_counter #(.CNT_W(CNT_W), .COUNT_DOWN(COUNT_DOWN)) u_n_cnt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (accept),
      .limit_i (n_count_i),
      .run_i   (state == S_RESTART),
      .tick_i  (slow_tick_i),
      .done_o  (n_done)
   );

   assign clocks_off  = (state == S_PDWN) || (state == S_RESTART);
   assign clk1m_en_o  = ~clocks_off;
   assign clk12m_en_o = ~clocks_off;
   assign seq_run_o   = ~clocks_off;
   assign pd_req_o    = (state == S_ARM) || (state == S_PDWN);
   assign cpu_lock_o  = (state != S_IDLE);
   assign wake_o      = (state == S_WAKE);
   assign irq_o       = wake_o & irq_en_i;

   // R4: a tick while requesting with clocks running stops the clocks
   p_stop_on_tick_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (pd_req_o && clk12m_en_o && slow_tick_i) |=> !clk12m_en_o && !seq_run_o);

   // R5: the power-down request only falls right after a slow tick
   p_pd_fall_tick_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(pd_req_o) |-> $past(slow_tick_i));

   // R6: clocks only return right after a slow tick
   p_clk_rise_tick_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(clk12m_en_o) |-> $past(slow_tick_i) && wake_o);

   // R7: wake-up pulse is one cycle wide
   p_wake_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      wake_o |=> !wake_o);

   // R9: lockout covers the request and the wake-up cycle
   p_lock_cover_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (pd_req_o || wake_o) |-> cpu_lock_o);

   // R2: the power-down request rises only after an enabled request
   p_pd_needs_hcc_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(pd_req_o) |-> $past(hcc_en_i) && $past(sleep_req_i));

endmodule

// File: tb/sleep_dur_ctrl_tb_top.sv
module sleep_dur_ctrl_tb_top;

   localparam int CW = 16;

   logic          clk_i = 1'b0;
   logic          rst_i = 1'b1;
   logic          slow_tick_i = 1'b0;
   logic          sleep_req_i = 1'b0;
   logic          hcc_en_i = 1'b0;
   logic          irq_en_i = 1'b0;
   logic [CW-1:0] m_count_i = '0;
   logic [CW-1:0] n_count_i = '0;
   logic pd_req_o, clk1m_en_o, clk12m_en_o, seq_run_o, cpu_lock_o, wake_o, irq_o;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk_i = ~clk_i;

   sleep_dur_ctrl #(.CNT_W(CW)) dut_i (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .slow_tick_i (slow_tick_i),
      .sleep_req_i (sleep_req_i),
      .hcc_en_i    (hcc_en_i),
      .irq_en_i    (irq_en_i),
      .m_count_i   (m_count_i),
      .n_count_i   (n_count_i),
      .pd_req_o    (pd_req_o),
      .clk1m_en_o  (clk1m_en_o),
      .clk12m_en_o (clk12m_en_o),
      .seq_run_o   (seq_run_o),
      .cpu_lock_o  (cpu_lock_o),
      .wake_o      (wake_o),
      .irq_o       (irq_o)
   );

   task automatic step();
      @(posedge clk_i);
      #1;
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_i = 1'b1;
      step(); step();
      rst_i = 1'b0;
      chk("R1 clk1m_en", clk1m_en_o, 1'b1);
      chk("R1 clk12m_en", clk12m_en_o, 1'b1);
      chk("R1 seq_run", seq_run_o, 1'b1);
      chk("R1 pd_req", pd_req_o, 1'b0);
      chk("R1 cpu_lock", cpu_lock_o, 1'b0);
      chk("R1 wake", wake_o, 1'b0);
      chk("R1 irq", irq_o, 1'b0);
   endtask

   task automatic t_hcc_off();
      hcc_en_i = 1'b0;
      sleep_req_i = 1'b1;
      for (int i = 0; i < 6; i++) begin
         slow_tick_i = i[0];
         step();
         chk("R2 pd_req stays low", pd_req_o, 1'b0);
         chk("R2 lock stays low", cpu_lock_o, 1'b0);
         chk("R2 clocks stay on", clk12m_en_o, 1'b1);
      end
      sleep_req_i = 1'b0;
      slow_tick_i = 1'b0;
      step();
   endtask

   task automatic t_sleep(input int m, input int n, input bit irq,
                          input bit tick_acc, input bit junk, input bit hold_req);
      hcc_en_i = 1'b1;
      sleep_req_i = 1'b1;
      irq_en_i = irq;
      m_count_i = CW'(m);
      n_count_i = CW'(n);
      slow_tick_i = tick_acc;
      step();
      chk("R3 pd_req after accept", pd_req_o, 1'b1);
      chk("R9 lock after accept", cpu_lock_o, 1'b1);
      chk("R3 clocks on after accept", clk12m_en_o, 1'b1);
      sleep_req_i = hold_req;
      slow_tick_i = 1'b0;
      if (junk) begin
         m_count_i = CW'(m + 7);
         n_count_i = CW'(n + 5);
      end
      step();
      chk("R3 clocks wait for tick", clk1m_en_o, 1'b1);
      slow_tick_i = 1'b1;
      step();
      slow_tick_i = 1'b0;
      chk("R4 clk1m off", clk1m_en_o, 1'b0);
      chk("R4 clk12m off", clk12m_en_o, 1'b0);
      chk("R4 seq_run off", seq_run_o, 1'b0);
      chk("R4 pd_req held", pd_req_o, 1'b1);
      for (int k = 0; k <= m; k++) begin
         step();
         slow_tick_i = 1'b1;
         step();
         slow_tick_i = 1'b0;
         if (k < m)
            chk(junk ? "R10 pd_req held (M latched)" : "R5 pd_req held", pd_req_o, 1'b1);
         else begin
            chk(junk ? "R10 pd_req released (M latched)" : "R5 pd_req released", pd_req_o, 1'b0);
            chk("R5 clocks still off", clk12m_en_o, 1'b0);
         end
      end
      for (int k = 0; k <= n; k++) begin
         step();
         slow_tick_i = 1'b1;
         step();
         slow_tick_i = 1'b0;
         if (k < n) begin
            chk(junk ? "R10 clocks off (N latched)" : "R6 clocks off", clk12m_en_o, 1'b0);
            chk("R7 no early wake", wake_o, 1'b0);
         end else begin
            chk(junk ? "R10 clocks back (N latched)" : "R6 clk12m back", clk12m_en_o, 1'b1);
            chk("R6 clk1m back", clk1m_en_o, 1'b1);
            chk("R6 seq_run back", seq_run_o, 1'b1);
            chk("R7 wake pulse", wake_o, 1'b1);
            chk("R8 irq follows enable", irq_o, irq);
            chk("R9 lock in wake cycle", cpu_lock_o, 1'b1);
         end
      end
      step();
      chk("R7 wake ends", wake_o, 1'b0);
      chk("R8 irq ends", irq_o, 1'b0);
      chk("R9 lock released", cpu_lock_o, 1'b0);
      chk("R11 no new sleep", pd_req_o, 1'b0);
      sleep_req_i = 1'b0;
      step();
      chk("R11 still idle", cpu_lock_o, 1'b0);
   endtask

   initial begin
      t_reset();
      t_hcc_off();
      t_sleep(3, 2, 1'b1, 1'b0, 1'b0, 1'b0);
      t_sleep(0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
      t_sleep(2, 4, 1'b1, 1'b1, 1'b0, 1'b0);
      t_sleep(4, 1, 1'b0, 1'b0, 1'b1, 1'b0);
      t_sleep(1, 3, 1'b1, 1'b0, 1'b0, 1'b1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule